// File: doc/BRIEF.md
# Flash Power-Mode Sequencer with Status Register

This block sequences an embedded flash bank and its charge pump through three power modes: sleep, standby and active (read). A 2-bit request input names the wanted mode. Raising the power level runs a programmable wait count for each step. Sleep to standby uses one counter and standby to active uses another. The reported mode changes only when the count for that step has run out. Lowering the power level takes effect on the next clock. A request for active while asleep passes through standby, and the two counts run one after the other.

A 16-bit status word is always readable on `rd_data`. It carries the committed mode, one busy flag for each wait counter, and a sticky latch that records a flash supply excursion. The latch is set by the pump's supply-status input and cleared by software writing 1 to its bit over a plain write strobe. An asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `flash_pwr_seq`

## Requirements
- R1: The mode field rd_data[1:0] uses 00 = sleep, 01 = standby, 11 = active. The value 10 is never reported, and the field reads 00 after reset.
- R2: From sleep, a request of standby or active starts the sleep-to-standby counter, loaded from sby_wait. Bit 2 reads 1 while it counts. The mode shows 01 exactly sby_wait+2 clocks after the request is presented, and bit 2 is high for sby_wait+1 of those clocks.
- R3: From standby, a request of active starts the standby-to-active counter, loaded from act_wait. Bit 3 reads 1 while it counts. The mode shows 11 exactly act_wait+2 clocks after the request, and bit 3 is high for act_wait+1 clocks.
- R4: A request of active while asleep runs the sleep-to-standby count and then, starting on the clock it ends, the standby-to-active count. The mode reads 01 between the two counts and reaches 11 after sby_wait+act_wait+3 clocks.
- R5: With no counter busy, a request for a lower-power mode (active to standby or sleep, standby to sleep) is reported on the next clock.
- R6: A request that changes while a counter runs is acted on only after that count completes. A drop to sleep during the sleep-to-standby count shows 01 when the count ends, then 00 one clock later.
- R7: A reload value of 0 finishes a step one clock after its counter starts, with the busy bit high for exactly one clock.
- R8: Bit 8 is set on the clock after supply_bad is seen high, and it stays set once supply_bad returns low.
- R9: A write with wr_data[8] = 1 clears bit 8. A write with wr_data[8] = 0 leaves it unchanged.
- R10: When supply_bad is high on the same clock as a clearing write, bit 8 stays set.
- R11: Bits 15:9 and 7:4 always read 0. Writes change no bit other than bit 8, and reset returns the whole word to 0.
- R12: The request code 10 is ignored: the mode is held and no counter starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_mode | input | 2 | Requested power mode (00 sleep, 01 standby, 11 active) |
| sby_wait | input | WAIT_W | Reload value of the sleep-to-standby wait counter |
| act_wait | input | WAIT_W | Reload value of the standby-to-active wait counter |
| supply_bad | input | 1 | Pump supply-status input, high when the flash supply is out of range |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 16 | Status register write data (only bit 8 acts, as write-1-to-clear) |
| rd_data | output | 16 | Status register read data |

## Verification
The bench uses the default counter width of 8 bits. It drives reload values of 0, 1 to 5, and 200, so a zero-length step, short steps and a step near the top of the 8-bit range can all be reached within a few hundred clocks. For each transition it counts how many clocks each busy bit is high and the clock on which the mode settles. It also uses requests that change mid-count and a set and clear of the fault latch on the same clock. These runs cover the chained sleep-to-active path and the rule that the set wins over the clear.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

  typedef enum logic [1:0] {
    PM_SLEEP = 2'b00,
    PM_STBY  = 2'b01,
    PM_RSVD  = 2'b10,
    PM_ACT   = 2'b11
  } pwr_mode_e;

  localparam int REG_W     = 16;
  localparam int BIT_SBUSY = 2;
  localparam int BIT_ABUSY = 3;
  localparam int BIT_FAULT = 8;

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwr_wait_ctr.sv
module pwr_wait_ctr #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] load,
  output logic              busy,
  output logic              done
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = load;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  assign cnt_en = start | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import flash_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       sby_busy,
  input  logic       sby_done,
  input  logic       act_busy,
  input  logic       act_done,
  output logic       sby_start,
  output logic       act_start,
  output pwr_mode_e  mode
);

  pwr_mode_e mode_q, mode_d;
  pwr_mode_e req_e;
  logic      idle;

  assign req_e = pwr_mode_e'(req);
  assign idle  = !sby_busy && !act_busy;

  always_comb begin
    mode_d    = mode_q;
    sby_start = 1'b0;
    act_start = 1'b0;
    if (sby_done) begin
      mode_d = PM_STBY;
      if (req_e == PM_ACT) act_start = 1'b1;
    end else if (act_done) begin
      mode_d = PM_ACT;
    end else if (idle) begin
      unique case (mode_q)
        PM_SLEEP: if (req_e == PM_STBY || req_e == PM_ACT) sby_start = 1'b1;
        PM_STBY: begin
          if (req_e == PM_ACT)        act_start = 1'b1;
          else if (req_e == PM_SLEEP) mode_d    = PM_SLEEP;
        end
        PM_ACT:  if (req_e == PM_STBY || req_e == PM_SLEEP) mode_d = req_e;
        default: mode_d = PM_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_SLEEP;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
  import flash_pwr_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_mode,
  input  logic [WAIT_W-1:0] sby_wait,
  input  logic [WAIT_W-1:0] act_wait,
  input  logic              supply_bad,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data
);

  logic      rst_sync_n;
  logic      sby_start, sby_busy, sby_done;
  logic      act_start, act_busy, act_done;
  pwr_mode_e mode;
  logic      fault_q, fault_d, fault_clr;

  pwr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwr_wait_ctr #(.WAIT_W(WAIT_W)) u_sby_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (sby_start),
    .load  (sby_wait),
    .busy  (sby_busy),
    .done  (sby_done)
  );

  pwr_wait_ctr #(.WAIT_W(WAIT_W)) u_act_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (act_start),
    .load  (act_wait),
    .busy  (act_busy),
    .done  (act_done)
  );

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (req_mode),
    .sby_busy  (sby_busy),
    .sby_done  (sby_done),
    .act_busy  (act_busy),
    .act_done  (act_done),
    .sby_start (sby_start),
    .act_start (act_start),
    .mode      (mode)
  );

  // Sticky supply fault: a set on the same clock as a clear takes precedence.
  assign fault_clr = wr_en && wr_data[BIT_FAULT];
  assign fault_d   = supply_bad || (fault_q && !fault_clr);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fault_q <= 1'b0;
    else             fault_q <= fault_d;
  end

  always_comb begin
    rd_data            = '0;
    rd_data[1:0]       = mode;
    rd_data[BIT_SBUSY] = sby_busy;
    rd_data[BIT_ABUSY] = act_busy;
    rd_data[BIT_FAULT] = fault_q;
  end

endmodule

// File: rtl/flash_pwr_seq_chk.sv
module flash_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  req_mode,
  input logic        supply_bad,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data
);

  AST_MODE_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] != 2'b10); // R1

  AST_SLEEP_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b00 && !rd_data[2]) |=> rd_data[1:0] == 2'b00); // R2

  AST_ACT_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b01 && !rd_data[3]) |=> rd_data[1:0] != 2'b11); // R3

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_data[3:2]) <= 1); // R4

  AST_DOWN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:2] == 2'b00 && rd_data[1:0] == 2'b11 && req_mode == 2'b00)
      |=> rd_data[1:0] == 2'b00); // R5

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |=> rd_data[8]); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8] && !(wr_en && wr_data[8])) |=> rd_data[8]); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:9] == 7'd0 && rd_data[7:4] == 4'd0); // R11

  AST_RSVD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:2] == 2'b00 && req_mode == 2'b10) |=> $stable(rd_data[1:0])); // R12

endmodule

bind flash_pwr_seq flash_pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_mode   (req_mode),
  .supply_bad (supply_bad),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data)
);

// File: tb/flash_pwr_seq_test.sv
module flash_pwr_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  req_mode;
  logic [7:0]  sby_wait, act_wait;
  logic        supply_bad, wr_en;
  logic [15:0] wr_data, rd_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  flash_pwr_seq uut (
    .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .sby_wait(sby_wait),
    .act_wait(act_wait), .supply_bad(supply_bad), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0] req;
    logic [7:0] ls;
    logic [7:0] la;
    logic [1:0] mode;
    logic [9:0] lat;
    logic [9:0] b2;
    logic [9:0] b3;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 8'd3,   8'd0, 2'b01, 10'd5,   10'd4,   10'd0}, // R2
    '{2'b11, 8'd0,   8'd2, 2'b11, 10'd4,   10'd0,   10'd3}, // R3
    '{2'b00, 8'd0,   8'd0, 2'b00, 10'd1,   10'd0,   10'd0}, // R5
    '{2'b11, 8'd1,   8'd4, 2'b11, 10'd8,   10'd2,   10'd5}, // R4
    '{2'b01, 8'd0,   8'd0, 2'b01, 10'd1,   10'd0,   10'd0}, // R5
    '{2'b00, 8'd0,   8'd0, 2'b00, 10'd1,   10'd0,   10'd0}, // R5
    '{2'b11, 8'd0,   8'd0, 2'b11, 10'd3,   10'd1,   10'd1}, // R7 R4
    '{2'b00, 8'd0,   8'd0, 2'b00, 10'd1,   10'd0,   10'd0}, // R5
    '{2'b01, 8'd0,   8'd0, 2'b01, 10'd2,   10'd1,   10'd0}, // R7
    '{2'b00, 8'd0,   8'd0, 2'b00, 10'd1,   10'd0,   10'd0}, // R5
    '{2'b01, 8'd200, 8'd0, 2'b01, 10'd202, 10'd201, 10'd0}  // R2
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic write(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    int first, b2c, b3c, rsv;
    rst_n = 1'b0; req_mode = 2'b00; sby_wait = '0; act_wait = '0;
    supply_bad = 1'b0; wr_en = 1'b0; wr_data = '0;
    do_reset();
    check("R1 R11 reset word", rd_data, 16'h0000);

    // Table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      req_mode = VEC[v].req; sby_wait = VEC[v].ls; act_wait = VEC[v].la;
      first = 0; b2c = 0; b3c = 0; rsv = 0;
      for (int k = 1; k <= int'(VEC[v].lat) + 3; k++) begin
        tick(1);
        if (rd_data[2]) b2c++;
        if (rd_data[3]) b3c++;
        if (rd_data[1:0] == 2'b10) rsv++;
        if (first == 0 && rd_data[1:0] == VEC[v].mode && rd_data[3:2] == 2'b00) first = k;
      end
      check($sformatf("R2/R3/R4/R5/R7 vec%0d latency", v), 16'(first), 16'(VEC[v].lat));
      check($sformatf("R2 R7 vec%0d bit2 clocks", v), 16'(b2c), 16'(VEC[v].b2));
      check($sformatf("R3 R7 vec%0d bit3 clocks", v), 16'(b3c), 16'(VEC[v].b3));
      check($sformatf("R1 vec%0d final mode, no 10", v), {14'(rsv), rd_data[1:0]}, {14'd0, VEC[v].mode});
    end

    // R4: standby shown between the two counts
    req_mode = 2'b00; tick(2);
    req_mode = 2'b11; sby_wait = 8'd2; act_wait = 8'd3;
    tick(4);
    check("R4 mid mode standby", {12'd0, rd_data[3:0]}, 16'h0009);
    tick(4);
    check("R4 reached active", {12'd0, rd_data[3:0]}, 16'h0003);

    // R6: drop to sleep during the sleep-to-standby count
    req_mode = 2'b00; tick(2);
    req_mode = 2'b01; sby_wait = 8'd5;
    tick(2);
    req_mode = 2'b00;
    tick(4);
    check("R6 held in sleep while counting", {12'd0, rd_data[3:0]}, 16'h0004);
    tick(1);
    check("R6 count end shows standby", {12'd0, rd_data[3:0]}, 16'h0001);
    tick(1);
    check("R6 then sleep", {12'd0, rd_data[3:0]}, 16'h0000);

    // R12: reserved request code
    req_mode = 2'b10; sby_wait = 8'd0;
    tick(5);
    check("R12 reserved request ignored", rd_data, 16'h0000);
    req_mode = 2'b00;

    // R8: fault latch set and sticky
    supply_bad = 1'b1; tick(1); supply_bad = 1'b0;
    check("R8 fault set", rd_data, 16'h0100);
    tick(3);
    check("R8 fault sticky", rd_data, 16'h0100);

    // R9: writing 0 leaves it, writing 1 clears it
    write(16'h0000);
    check("R9 write 0 no effect", rd_data, 16'h0100);
    // R11: writes to other bits are ignored
    write(16'hFEFF);
    check("R11 reserved writes ignored", rd_data, 16'h0100);
    write(16'h0100);
    check("R9 write 1 clears", rd_data, 16'h0000);

    // R10: set and clear on the same clock
    supply_bad = 1'b1; wr_en = 1'b1; wr_data = 16'h0100;
    tick(1);
    supply_bad = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R10 set wins over clear", rd_data, 16'h0100);

    // R11: reset mid-operation clears everything
    req_mode = 2'b11; sby_wait = 8'd0; act_wait = 8'd0;
    tick(5);
    check("R11 active with fault before reset", rd_data, 16'h0103);
    req_mode = 2'b00;
    do_reset();
    check("R11 reset clears word", rd_data, 16'h0000);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired, run hung (all requirements)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule